// File: doc/BRIEF.md
# Multi-Port EDID Buffer with Per-Port Address Patching

This block holds a single 256-byte display-capability (EDID) image and presents it to three video input ports at once. A host fills the image and a small set of control registers through one byte-wide write port. Each input port has its own read port: an address goes in, and the data byte comes out one clock later. Port 1 sees the image exactly as it was loaded. Ports 2 and 3 see the same image with three bytes replaced: the two bytes that hold the CEC physical address, and the block checksum at offset 255.

The replacement values come from one of two places. In hardware mode the block derives them itself. It adds the port number to the leading digit of port 1's address, and it corrects the checksum by the change it made. In software mode the host supplies each port's two address bytes and its checksum byte through registers.

A control register decides when the content is valid. Until the host marks it ready, every port reads 0xFF and a not-ready flag is raised. While the content is ready, writes to the image are locked out.

Top module: `edid_multiport_buf`

## Requirements
- R1: Port 1 returns the stored image byte at the address presented one clock earlier, with no substitution at any offset.
- R2: A physical address A.B.C.D is held as two bytes: A in bits 7:4 and B in bits 3:0 of the first byte, and C and D in the same way in the second byte. In hardware mode, port k (k = 2 or 3) reads the first address byte with its upper nibble increased by k-1, wrapping modulo 16. Its second address byte is returned unchanged.
- R3: In hardware mode, port k reads byte 255 as the stored byte 255 minus the difference between the patched and stored address bytes, modulo 256. The sum of the three bytes is therefore the same as in the stored image.
- R4: Control register 0x10 works as follows. Bit 0 set selects software mode. The content is ready only when bits 2 and 1 are both set, so 0x07 means software mode and ready, and 0x06 means hardware mode and ready. While the content is not ready, every port reads 0xFF and not_ready is 1. The flag and the data gating follow the register from the clock after the write.
- R5: In software mode, port 2 reads its first address byte, second address byte and checksum from registers 0x11, 0x12 and 0x13. Port 3 reads the same three bytes from 0x14, 0x15 and 0x16.
- R6: Register 0x17 holds the image offset of the first address byte. The second address byte is at that offset plus one. Every other offset except 255 reads as stored on all ports.
- R7: The three read ports are served in the same cycle. A register write in the same cycle as a read of a byte that depends on that register returns the value from before the write.
- R8: While the content is ready, image writes are ignored. After ready is cleared, an image write takes effect.
- R9: After reset, every port reads 0xFF, not_ready is 1, hardware mode is selected and the address offset is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_reg | input | 1 | 1 = write to the register space, 0 = write to the image |
| host_addr | input | 8 | Image offset, or register address |
| host_wdata | input | 8 | Host write data |
| port_addr | input | 24 | Read addresses, port 1 in bits 7:0, port 2 in bits 15:8, port 3 in bits 23:16 |
| port_data | output | 24 | Read data, packed the same way as port_addr |
| not_ready | output | 1 | 1 while the content is not marked ready |

## Verification
A host register write and a port read can land in the same cycle. The bench provokes this while the content is ready in software mode. In one cycle it rewrites port 2's first address byte and reads port 2 at the patched offset, then expects the old value, and reads again to expect the new one. The lock-out is exercised the same way. An image write made while ready must leave port 1's data unchanged, and after ready is cleared and set again the same write must show.

// File: rtl/edid_buf_pkg.sv
package edid_buf_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t IDLE_BYTE    = 8'hFF;
  localparam int    CTRL_REG     = 'h10;
  localparam int    PATCH_FIELDS = 3;

  typedef struct packed {
    byte_t pa_hi;
    byte_t pa_lo;
    byte_t cks;
  } sw_patch_t;
endpackage

// File: rtl/edid_ctrl_regs.sv
module edid_ctrl_regs
  import edid_buf_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  byte_t             wr_data,
  output logic              ready,
  output logic              sw_mode,
  output logic [ADDR_W-1:0] pa_off,
  output sw_patch_t         sw_tab [NUM_PORTS]
);
  localparam int OFF_REG = CTRL_REG + 1 + PATCH_FIELDS * (NUM_PORTS - 1);

  byte_t             ctrl_q, ctrl_d;
  logic [ADDR_W-1:0] off_q, off_d;
  sw_patch_t         tab_q [NUM_PORTS];
  sw_patch_t         tab_d [NUM_PORTS];

  always_comb begin
    ctrl_d = ctrl_q;
    off_d  = off_q;
    for (int k = 0; k < NUM_PORTS; k++) tab_d[k] = tab_q[k];
    if (wr_en) begin
      if (wr_addr == ADDR_W'(CTRL_REG)) ctrl_d = wr_data;
      if (wr_addr == ADDR_W'(OFF_REG))  off_d  = ADDR_W'(wr_data);
      for (int k = 1; k < NUM_PORTS; k++) begin
        if (wr_addr == ADDR_W'(CTRL_REG + 1 + PATCH_FIELDS * (k - 1)))
          tab_d[k].pa_hi = wr_data;
        if (wr_addr == ADDR_W'(CTRL_REG + 2 + PATCH_FIELDS * (k - 1)))
          tab_d[k].pa_lo = wr_data;
        if (wr_addr == ADDR_W'(CTRL_REG + 3 + PATCH_FIELDS * (k - 1)))
          tab_d[k].cks   = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      off_q  <= '0;
      for (int k = 0; k < NUM_PORTS; k++) tab_q[k] <= '0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
      off_q  <= off_d;
      for (int k = 0; k < NUM_PORTS; k++) tab_q[k] <= tab_d[k];
    end
  end

  assign ready   = ctrl_q[2] & ctrl_q[1];
  assign sw_mode = ctrl_q[0];
  assign pa_off  = off_q;
  always_comb for (int k = 0; k < NUM_PORTS; k++) sw_tab[k] = tab_q[k];

  // R4: the ready-with-software code takes effect on the next clock
  a_r4_ready_code: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(CTRL_REG) && wr_data == 8'h07) |=> (ready && sw_mode));

  // R9: the offset register only moves on a host write
  a_r9_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pa_off));
endmodule

// File: rtl/edid_image_ram.sv
module edid_image_ram
  import edid_buf_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              lock,
  input  logic [ADDR_W-1:0] wr_addr,
  input  byte_t             wr_data,
  input  logic [ADDR_W-1:0] rd_addr [NUM_PORTS],
  input  logic [ADDR_W-1:0] pa_off,
  output byte_t             rd_byte [NUM_PORTS],
  output byte_t             pa0_byte,
  output byte_t             pa1_byte,
  output byte_t             cks_byte
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] CKS_ADDR = {ADDR_W{1'b1}};

  byte_t mem [DEPTH];
  logic  mem_we;

  assign mem_we = wr_en & ~lock;

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_addr] <= wr_data;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    assign rd_byte[p] = mem[rd_addr[p]];
  end

  assign pa0_byte = mem[pa_off];
  assign pa1_byte = mem[ADDR_W'(pa_off + 1'b1)];
  assign cks_byte = mem[CKS_ADDR];

  // R8: while locked, the stored checksum byte cannot change
  a_r8_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(cks_byte));
endmodule

// File: rtl/edid_port_lane.sv
module edid_port_lane
  import edid_buf_pkg::*;
#(
  parameter int PORT_IDX = 0,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready,
  input  logic              sw_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  byte_t             raw_byte,
  input  logic [ADDR_W-1:0] pa_off,
  input  byte_t             pa0_st,
  input  byte_t             pa1_st,
  input  byte_t             cks_st,
  input  sw_patch_t         sw_val,
  output byte_t             rd_data
);
  localparam logic              IS_BASE  = (PORT_IDX == 0);
  localparam logic [3:0]        STEP     = 4'(PORT_IDX);
  localparam logic [ADDR_W-1:0] CKS_ADDR = {ADDR_W{1'b1}};

  byte_t hw_pa0, hw_pa1, hw_cks, pat, data_d, data_q;

  assign hw_pa0 = {pa0_st[7:4] + STEP, pa0_st[3:0]};
  assign hw_pa1 = pa1_st;
  assign hw_cks = cks_st - (hw_pa0 - pa0_st) - (hw_pa1 - pa1_st);

  always_comb begin
    pat = raw_byte;
    if (rd_addr == pa_off)
      pat = sw_mode ? sw_val.pa_hi : hw_pa0;
    else if (rd_addr == ADDR_W'(pa_off + 1'b1))
      pat = sw_mode ? sw_val.pa_lo : hw_pa1;
    else if (rd_addr == CKS_ADDR)
      pat = sw_mode ? sw_val.cks : hw_cks;
    if (!ready)       data_d = IDLE_BYTE;
    else if (IS_BASE) data_d = raw_byte;
    else              data_d = pat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= IDLE_BYTE;
    else        data_q <= data_d;
  end

  assign rd_data = data_q;

  // R4: not ready means the idle pattern on the following clock
  a_r4_idle_ff: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> (rd_data == IDLE_BYTE));

  // R1: the base port passes stored bytes through after one clock
  a_r1_base_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && IS_BASE) |=> (rd_data == $past(raw_byte)));

  // R3: hardware patching keeps the three-byte sum unchanged
  a_r3_cks_balance: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !sw_mode) |-> (8'(hw_pa0 + hw_pa1 + hw_cks) == 8'(pa0_st + pa1_st + cks_st)));

  // R2: the leading digit moves by the port step and nothing else changes
  a_r2_lead_digit: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !sw_mode) |-> (byte_t'(hw_pa0 - pa0_st) == {STEP, 4'h0} && hw_pa1 == pa1_st));
endmodule

// File: rtl/edid_multiport_buf.sv
module edid_multiport_buf
  import edid_buf_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_we,
  input  logic                       host_reg,
  input  logic [ADDR_W-1:0]          host_addr,
  input  logic [7:0]                 host_wdata,
  input  logic [NUM_PORTS*ADDR_W-1:0] port_addr,
  output logic [NUM_PORTS*8-1:0]     port_data,
  output logic                       not_ready
);
  logic              rst_s1, rst_sync_n;
  logic              ready, sw_mode;
  logic [ADDR_W-1:0] pa_off;
  sw_patch_t         sw_tab [NUM_PORTS];
  logic [ADDR_W-1:0] rd_addr [NUM_PORTS];
  byte_t             rd_byte [NUM_PORTS];
  byte_t             pa0_byte, pa1_byte, cks_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  edid_ctrl_regs #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (host_we & host_reg),
    .wr_addr (host_addr),
    .wr_data (host_wdata),
    .ready   (ready),
    .sw_mode (sw_mode),
    .pa_off  (pa_off),
    .sw_tab  (sw_tab)
  );

  edid_image_ram #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_ram (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (host_we & ~host_reg),
    .lock     (ready),
    .wr_addr  (host_addr),
    .wr_data  (host_wdata),
    .rd_addr  (rd_addr),
    .pa_off   (pa_off),
    .rd_byte  (rd_byte),
    .pa0_byte (pa0_byte),
    .pa1_byte (pa1_byte),
    .cks_byte (cks_byte)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
    assign rd_addr[p] = port_addr[p*ADDR_W +: ADDR_W];

    edid_port_lane #(.PORT_IDX(p), .ADDR_W(ADDR_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .ready    (ready),
      .sw_mode  (sw_mode),
      .rd_addr  (rd_addr[p]),
      .raw_byte (rd_byte[p]),
      .pa_off   (pa_off),
      .pa0_st   (pa0_byte),
      .pa1_st   (pa1_byte),
      .cks_st   (cks_byte),
      .sw_val   (sw_tab[p]),
      .rd_data  (port_data[p*8 +: 8])
    );
  end

  assign not_ready = ~ready;
endmodule

// File: tb/edid_multiport_buf_tb_top.sv
module edid_multiport_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0, host_reg = 1'b0;
  logic [7:0]  host_addr = '0, host_wdata = '0;
  logic [23:0] port_addr = '0;
  logic [23:0] port_data;
  logic        not_ready;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] m_img [256];
  logic [7:0] m_ctrl = 8'h00, m_off = 8'h00;
  logic [7:0] m_hi [3], m_lo [3], m_ck [3];

  always #4 clk = ~clk;

  edid_multiport_buf dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_reg(host_reg),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .port_addr(port_addr), .port_data(port_data), .not_ready(not_ready)
  );

  function automatic bit m_ready();
    return m_ctrl[2] & m_ctrl[1];
  endfunction

  function automatic logic [7:0] model_byte(int p, logic [7:0] a);
    logic [7:0] off1 = m_off + 8'd1;
    logic [7:0] st0  = m_img[m_off];
    logic [7:0] p0   = {st0[7:4] + 4'(p), st0[3:0]};
    if (!m_ready()) return 8'hFF;
    if (p == 0) return m_img[a];
    if (m_ctrl[0]) begin
      if (a == m_off) return m_hi[p];
      if (a == off1)  return m_lo[p];
      if (a == 8'hFF) return m_ck[p];
    end else begin
      if (a == m_off) return p0;
      if (a == off1)  return m_img[off1];
      if (a == 8'hFF) return m_img[255] - {4'(p), 4'h0};
    end
    return m_img[a];
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic model_write(bit isreg, logic [7:0] a, logic [7:0] d);
    if (isreg) begin
      if (a == 8'h10) m_ctrl = d;
      if (a == 8'h17) m_off = d;
      for (int k = 1; k < 3; k++) begin
        if (a == 8'(8'h11 + 3*(k-1))) m_hi[k] = d;
        if (a == 8'(8'h12 + 3*(k-1))) m_lo[k] = d;
        if (a == 8'(8'h13 + 3*(k-1))) m_ck[k] = d;
      end
    end else if (!m_ready()) begin
      m_img[a] = d;
    end
  endtask

  task automatic hwr(bit isreg, logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_reg = isreg; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    model_write(isreg, a, d);
  endtask

  task automatic rd3(string req, logic [7:0] a0, logic [7:0] a1, logic [7:0] a2);
    @(negedge clk);
    port_addr = {a2, a1, a0};
    @(negedge clk);
    chk(req, port_data[7:0],   model_byte(0, a0));
    chk(req, port_data[15:8],  model_byte(1, a1));
    chk(req, port_data[23:16], model_byte(2, a2));
    chk({req, " flag"}, {7'd0, not_ready}, {7'd0, !m_ready()});
  endtask

  task automatic load_round(bit sw, bit wrap);
    logic [7:0] off;
    hwr(1, 8'h10, sw ? 8'h01 : 8'h00);
    for (int i = 0; i < 256; i++) hwr(0, 8'(i), 8'($urandom));
    off = 8'(128 + ($urandom % 126));
    hwr(1, 8'h17, off);
    if (wrap) hwr(0, off, {4'hF, 4'($urandom)});
    for (int k = 0; k < 6; k++) hwr(1, 8'(8'h11 + k), 8'($urandom));
    rd3("R4 not ready", off, off, 8'hFF);
    hwr(1, 8'h10, sw ? 8'h07 : 8'h06);
  endtask

  task automatic sweep(string tag);
    rd3(tag, m_off, m_off, m_off);
    rd3(tag, m_off + 8'd1, m_off + 8'd1, m_off + 8'd1);
    rd3(tag, 8'hFF, 8'hFF, 8'hFF);
    for (int i = 0; i < 40; i++)
      rd3(tag, 8'($urandom), 8'($urandom), 8'($urandom));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] old;
    void'($urandom(32'd7431));
    for (int k = 0; k < 3; k++) begin m_hi[k] = 0; m_lo[k] = 0; m_ck[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset data", port_data[7:0], 8'hFF);
    chk("R9 reset data", port_data[23:16], 8'hFF);
    chk("R9 reset flag", {7'd0, not_ready}, 8'd1);

    // R2 R3 hardware mode with nibble wrap
    load_round(0, 1);
    sweep("R2 R3 hw wrap");
    // R5 R6 software mode
    load_round(1, 0);
    sweep("R5 R6 sw");

    // R7 same-cycle register write and read
    @(negedge clk);
    old = model_byte(1, m_off);
    host_we = 1; host_reg = 1; host_addr = 8'h11; host_wdata = ~m_hi[1];
    port_addr = {8'h00, m_off, m_off};
    @(negedge clk);
    host_we = 0;
    chk("R7 collide old", port_data[15:8], old);
    model_write(1, 8'h11, ~m_hi[1]);
    rd3("R7 after write", m_off, m_off, m_off);

    // R8 image write ignored while ready
    old = m_img[m_off + 8'd3];
    hwr(0, m_off + 8'd3, ~old);
    rd3("R8 locked", m_off + 8'd3, 8'h00, 8'h01);
    chk("R8 locked model", m_img[m_off + 8'd3], old);
    hwr(1, 8'h10, 8'h01);
    hwr(0, m_off + 8'd3, ~old);
    hwr(1, 8'h10, 8'h07);
    rd3("R8 reloaded", m_off + 8'd3, 8'h02, 8'h03);
    chk("R8 reloaded value", port_data[7:0], ~old);

    // R1 R2 R3 further random rounds
    for (int r = 0; r < 4; r++) begin
      load_round(r[0], 0);
      sweep("R1 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule